// File: doc/BRIEF.md
# Cache fill slot selection controller

This block sits beside a small instruction cache and decides, at the end of every miss, whether the fetched instruction data is worth keeping and which slot it goes into. It times each miss from the cycle the miss is flagged to the cycle the fill data arrives. Only fills that took longer than a programmable 2-bit clock threshold are written. Slow fills earn a slot, and fast ones are left to be fetched again.

Two replacement policies are available. The first is a pointer that sweeps up and down through the slots. The second is the state of a free-running maximal-length LFSR. Fills that come from table-read (constant fetch) instructions can be pinned to slot 0. Every completed miss also adds its latency to a saturating miss-penalty accumulator. Software reads the accumulator through a small register port, and the low bits are captured into a latch whenever the high field is read.

The write toward the cache is a one-cycle strobe with a slot index and has no ready. The cache array takes a write in any cycle, so there is no back-pressure. The miss and fill inputs are plain strobes and are never stalled by this block.

Top module: `fill_slot_ctrl`

## Requirements
- R1: After reset, cache_we is 0, and a read of register 0 returns 8'h04: rebound policy, fixed-slot enable set, threshold 0, latch 0.
- R2: A write to register 0 (reg_addr=0) stores wdata[3] as the policy select (0 rebound, 1 random), wdata[2] as the table-read fixed-slot enable and wdata[1:0] as the threshold. wdata[7:4] is ignored.
- R3: The latency of a fill is the number of clock edges from the edge that samples miss_start to the edge that samples fill_done. The fill is written (cache_we=1 in the cycle after the fill_done edge) exactly when that latency exceeds the threshold.
- R4: With rebound selected, successive written slots run 0,1,…,31,30,…,0,1,… The pointer moves only on writes that used it.
- R5: With random selected, the slot is the state of a 5-bit LFSR sampled at the fill_done edge. The LFSR is seeded to 1 at reset, steps on every clock as next={s[3:0], s[4]^s[2]}, and is never 0.
- R6: With the fixed-slot enable set, a fill with fill_is_movc=1 is written to slot 0 under either policy, and it does not move the rebound pointer.
- R7: With the fixed-slot enable clear, a fill with fill_is_movc=1 takes its slot from the selected policy like any other fill.
- R8: Each completed fill, written or not, adds its latency (saturated at 255) to a 13-bit accumulator that saturates at 8191.
- R9: A read of register 1 returns accumulator bits 12:5 in reg_rdata one cycle after the strobe. The same strobe copies accumulator bits 4:1 into the latch shown in bits 7:4 of register 0. Register 0 shows the latched copy, not the live value.
- R10: fill_done with no miss outstanding is ignored: no write, and the accumulator is unchanged.
- R11: cache_we is a single-cycle strobe and is raised only in the cycle after a fill_done edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_start | input | 1 | Strobe: a cache miss begins; restarts the latency count |
| fill_done | input | 1 | Strobe: fill data for the outstanding miss has arrived |
| fill_is_movc | input | 1 | Qualifies fill_done: the fill comes from a table-read instruction |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register select: 0 configuration, 1 penalty high field |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after reg_rd |
| cache_we | output | 1 | Cache write strobe |
| cache_slot | output | 5 | Slot index for the cache write |

## Verification
The bench sweeps every threshold against latencies on both sides of it. A design that compared with >= or counted one edge off would cache fills it should drop. It drives more than one full up-and-down pass of the rebound pointer, so a design that wrapped instead of reversing, or that repeated an end slot twice, would show a wrong slot. Table-read fills under both fixed-slot settings expose a pinned fill that still moves the pointer. A stray fill_done, a long miss past the latency limit and enough misses to saturate the accumulator are read back through the latch. This exposes a wrapping accumulator, a latch that tracks live data, and counting of spurious fills.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef struct packed {
    logic       alg;   // 0 rebound sweep, 1 LFSR
    logic       fixm;  // table-read fills pinned to slot 0
    logic [1:0] thr;   // fill kept when latency > thr
  } fsc_cfg_t;

  localparam logic [3:0] CFG_RESET = 4'b0100;

  typedef enum logic {
    REG_CFG    = 1'b0,
    REG_PEN_HI = 1'b1
  } fsc_reg_e;
endpackage

// File: rtl/fsc_cfg_regs.sv
module fsc_cfg_regs
  import fsc_pkg::*;
#(
  parameter int ACC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic             addr,
  input  logic [7:0]       wdata,
  input  logic [ACC_W-1:0] acc,
  output fsc_cfg_t         cfg,
  output logic [7:0]       rdata
);
  localparam int LO_W = 4;

  logic [LO_W-1:0] lat_lo;
  logic [7:0]      hi_field;

  assign hi_field = 8'(acc >> (LO_W + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= fsc_cfg_t'(CFG_RESET);
      lat_lo <= '0;
      rdata  <= '0;
    end else begin
      if (wr && addr == REG_CFG) cfg <= fsc_cfg_t'(wdata[3:0]);
      if (rd) begin
        if (addr == REG_CFG) begin
          rdata <= {lat_lo, cfg};
        end else begin
          rdata  <= hi_field;
          lat_lo <= acc[LO_W:1];
        end
      end
    end
  end

  // R9: the latch only moves on a high-field read
  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && addr == REG_PEN_HI) |=> lat_lo == $past(lat_lo));

  // R2: configuration changes only through a register-0 write
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == REG_CFG) |=> cfg == $past(cfg));
endmodule

// File: rtl/fsc_miss_timer.sv
module fsc_miss_timer #(
  parameter int LAT_W = 8,
  parameter int ACC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_start,
  input  logic             fill_done,
  output logic             done,
  output logic [LAT_W-1:0] lat,
  output logic [ACC_W-1:0] acc
);
  localparam logic [LAT_W-1:0] LAT_MAX = '1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic             busy;
  logic [LAT_W-1:0] cnt;
  logic [ACC_W:0]   sum;

  assign done = fill_done && busy;
  assign lat  = (cnt == LAT_MAX) ? LAT_MAX : cnt + 1'b1;
  assign sum  = {1'b0, acc} + (ACC_W + 1)'(lat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (miss_start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy && cnt != LAT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (done) acc <= sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
  end

  // R8: latency counter sticks at its ceiling during a long miss
  a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt == LAT_MAX && !miss_start && !fill_done |=> cnt == LAT_MAX);

  // R8: accumulator never wraps downward
  a_r8_acc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> acc >= $past(acc));

  // R10: without a completed fill the accumulator holds
  a_r10_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_done |=> $stable(acc));
endmodule

// File: rtl/fsc_slot_pick.sv
module fsc_slot_pick
  import fsc_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              movc,
  input  fsc_cfg_t          cfg,
  output logic              we,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = '1;
  localparam logic [SLOT_W-1:0] SEED = SLOT_W'(1);

  logic [SLOT_W-1:0] lfsr;
  logic              fb;
  logic [SLOT_W-1:0] ptr;
  logic              up;
  logic              pinned;
  logic [SLOT_W-1:0] pick;

  generate
    if (SLOT_W == 4)      begin : g_fb4 assign fb = lfsr[3] ^ lfsr[2]; end
    else if (SLOT_W == 5) begin : g_fb5 assign fb = lfsr[4] ^ lfsr[2]; end
    else if (SLOT_W == 6) begin : g_fb6 assign fb = lfsr[5] ^ lfsr[4]; end
    else                  begin : g_fb7 assign fb = lfsr[6] ^ lfsr[5]; end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[SLOT_W-2:0], fb};
  end

  assign pinned = movc && cfg.fixm;
  assign pick   = pinned ? '0 : (cfg.alg ? lfsr : ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      up  <= 1'b1;
    end else if (take && !pinned && !cfg.alg) begin
      if (up) begin
        if (ptr == LAST) begin up <= 1'b0; ptr <= ptr - 1'b1; end
        else ptr <= ptr + 1'b1;
      end else begin
        if (ptr == '0) begin up <= 1'b1; ptr <= ptr + 1'b1; end
        else ptr <= ptr - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we   <= 1'b0;
      slot <= '0;
    end else begin
      we <= take;
      if (take) slot <= pick;
    end
  end

  // R5: the random source never reaches the all-zero lock-up state
  a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // R4: the rebound pointer moves by exactly one slot when it moves
  a_r4_rebound_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> (ptr == $past(ptr) + 1'b1) || (ptr == $past(ptr) - 1'b1));

  // R6: a pinned fill leaves the rebound pointer where it was
  a_r6_pin_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    take && pinned |=> $stable(ptr));
endmodule

// File: rtl/fill_slot_ctrl.sv
module fill_slot_ctrl
  import fsc_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int LAT_W  = 8,
  parameter int ACC_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_start,
  input  logic              fill_done,
  input  logic              fill_is_movc,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              cache_we,
  output logic [SLOT_W-1:0] cache_slot
);
  fsc_cfg_t         cfg;
  logic             done;
  logic [LAT_W-1:0] lat;
  logic [ACC_W-1:0] acc;
  logic             take;

  fsc_cfg_regs #(.ACC_W(ACC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .acc(acc), .cfg(cfg), .rdata(reg_rdata)
  );

  fsc_miss_timer #(.LAT_W(LAT_W), .ACC_W(ACC_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .miss_start(miss_start), .fill_done(fill_done),
    .done(done), .lat(lat), .acc(acc)
  );

  assign take = done && (lat > LAT_W'(cfg.thr));

  fsc_slot_pick #(.SLOT_W(SLOT_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .take(take), .movc(fill_is_movc), .cfg(cfg),
    .we(cache_we), .slot(cache_slot)
  );

  // R11: a cache write always follows a sampled fill_done
  a_r11_we_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |-> $past(fill_done));

  // R6: pinned table-read fills land in slot 0
  a_r6_fixed_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we && $past(fill_is_movc && cfg.fixm) |-> cache_slot == '0);

  // R3: a kept fill always exceeded the threshold in force
  a_r3_over_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |-> $past(lat) > LAT_W'($past(cfg.thr)));
endmodule

// File: tb/fill_slot_ctrl_tb.sv
module fill_slot_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       miss_start = 1'b0, fill_done = 1'b0, fill_is_movc = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cache_we;
  logic [4:0] cache_slot;

  int errors = 0, checks = 0;
  bit finished = 0;

  // bench model
  int m_ptr = 0; bit m_up = 1;
  int m_acc = 0; int m_latch = 0;
  bit m_alg = 0, m_fixm = 1; int m_thr = 0;
  logic [4:0] m_lfsr;

  always #2 clk = ~clk;

  fill_slot_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .miss_start(miss_start), .fill_done(fill_done),
    .fill_is_movc(fill_is_movc), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cache_we(cache_we), .cache_slot(cache_slot)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_lfsr <= 5'd1;
    else        m_lfsr <= {m_lfsr[3:0], m_lfsr[4] ^ m_lfsr[2]};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (a == 1'b0) begin
      m_alg = d[3]; m_fixm = d[2]; m_thr = int'(d[1:0]);
    end
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
    if (a == 1'b1) m_latch = (m_acc >> 1) & 15;
  endtask

  task automatic step_ptr();
    if (m_up) begin
      if (m_ptr == 31) begin m_up = 0; m_ptr = 30; end else m_ptr++;
    end else begin
      if (m_ptr == 0) begin m_up = 1; m_ptr = 1; end else m_ptr--;
    end
  endtask

  task automatic do_miss(input int lat, input bit movc, input string req);
    int el; bit exp_we; int exp_slot; logic [4:0] snap;
    @(negedge clk); miss_start = 1;
    @(negedge clk); miss_start = 0;
    repeat (lat - 1) @(negedge clk);
    fill_done = 1; fill_is_movc = movc; snap = m_lfsr;
    @(negedge clk); fill_done = 0; fill_is_movc = 0;
    el = (lat > 255) ? 255 : lat;
    exp_we = el > m_thr;
    check({req, " we"}, int'(cache_we), int'(exp_we));
    if (exp_we) begin
      if (movc && m_fixm) exp_slot = 0;
      else if (m_alg) exp_slot = int'(snap);
      else begin exp_slot = m_ptr; step_ptr(); end
      check({req, " slot"}, int'(cache_slot), exp_slot);
    end
    m_acc = (m_acc + el > 8191) ? 8191 : m_acc + el;
  endtask

  task automatic check_acc(input string req);
    logic [7:0] v;
    rd_reg(1'b1, v);
    check({req, " hi field"}, int'(v), (m_acc >> 5) & 255);
    rd_reg(1'b0, v);
    check({req, " latched lo"}, int'(v[7:4]), m_latch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 cache_we after reset", int'(cache_we), 0);
    rd_reg(1'b0, v);
    check("R1 reset cfg", int'(v), 8'h04);

    // R2 upper write bits ignored, lower stored
    wr_reg(1'b0, 8'hFB);
    rd_reg(1'b0, v);
    check("R2 cfg readback", int'(v), 8'h0B);
    wr_reg(1'b0, 8'h04);

    // R3 sweep of threshold against latency (rebound)
    for (int t = 0; t < 4; t++) begin
      wr_reg(1'b0, 8'(4 + t));
      for (int l = 1; l <= 5; l++) do_miss(l, 0, "R3 threshold sweep");
    end

    // R9 latch not yet loaded: still 0 after misses
    rd_reg(1'b0, v);
    check("R9 latch before hi read", int'(v[7:4]), 0);
    check_acc("R9 after sweep");
    do_miss(3, 0, "R9 extra miss");
    rd_reg(1'b0, v);
    check("R9 latch holds old copy", int'(v[7:4]), m_latch);

    // R4 full rebound passes, latency 1 threshold 0
    wr_reg(1'b0, 8'h00);
    for (int i = 0; i < 70; i++) do_miss(1, 0, "R4 rebound");
    // R7 table-read fill uses rebound when not pinned
    for (int i = 0; i < 3; i++) do_miss(2, 1, "R7 movc rebound");
    // R6 pinned in rebound; pointer not moved (next normal fill checks it)
    wr_reg(1'b0, 8'h04);
    do_miss(2, 1, "R6 pinned rebound");
    do_miss(2, 0, "R6 pointer unmoved");
    do_miss(1, 1, "R6 pinned rebound 2");
    do_miss(1, 0, "R6 pointer unmoved 2");

    // R5 random policy
    wr_reg(1'b0, 8'h08);
    for (int i = 0; i < 12; i++) do_miss(1 + (i % 6), 0, "R5 random");
    // R7 table-read fill under random, not pinned
    do_miss(3, 1, "R7 movc random");
    // R6 pinned under random
    wr_reg(1'b0, 8'h0C);
    do_miss(4, 1, "R6 pinned random");
    do_miss(2, 0, "R5 random after pin");

    // R10 stray fill_done
    @(negedge clk); fill_done = 1;
    @(negedge clk); fill_done = 0;
    check("R10 stray fill no write", int'(cache_we), 0);
    check_acc("R10 acc unchanged");

    // R11 strobe lasts one cycle
    wr_reg(1'b0, 8'h00);
    do_miss(2, 0, "R11 write");
    @(negedge clk);
    check("R11 we single cycle", int'(cache_we), 0);

    // R8 latency saturation then accumulator saturation
    do_miss(300, 0, "R8 long miss");
    check_acc("R8 latency capped");
    for (int i = 0; i < 34; i++) do_miss(300, 0, "R8 fill");
    check_acc("R8 acc saturated");
    check("R8 acc at ceiling", m_acc, 8191);

    report();
  end
endmodule